// File: doc/BRIEF.md
# Outbound IPv4 Header Encapsulator for Secured Traffic

This block sits in the outbound path of a security gateway. It takes a plain 20-byte IPv4 header with no options, together with the per-flow association record that says which security protocol and which mode apply. It produces the outer IPv4 header that goes in front of the security header. The original header comes in as five 32-bit words on a valid/ready stream. The rewritten header leaves on a second valid/ready stream as five words with a last marker, and a two-bit exception code travels alongside it.

The record selects one of two modes. In transport mode, the existing header is kept, and only its protocol, total length and checksum change. In tunnel mode, a new header is built, addressed between the two tunnel endpoints, and the whole original packet becomes its payload. In both modes the checksum is computed again. A packet that would grow beyond the configured MTU is still emitted, but it is marked for the control processor. It is marked for fragmentation when fragmenting is allowed, and for discard when the don't-fragment bit forbids it.

Top module: `secgw_encap`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `out_valid` is low and `in_ready` is high.
- R2: The header is taken as five words, word 0 first, with bits 31:24 of word 0 holding the version/IHL byte. The association record inputs (`sa_*`) are sampled only in the cycle the fifth word is accepted. While a result is waiting or being sent, `in_ready` is low.
- R3: In transport mode (`sa_tunnel`=0), byte 2 of word 2 (bits 23:16) is replaced by 50 when `sa_is_esp`=1 and by 51 when it is 0. Words 1, 3 and 4 and all other bytes of words 0 and 2, except the length and checksum fields, are passed through unchanged.
- R4: The output total length (word 0 bits 15:0) is the input total length plus `sa_sec_len`, plus a further 20 in tunnel mode, taken modulo 65536.
- R5: In tunnel mode the output header has version/IHL byte 0x45, the type-of-service byte copied from input word 0 bits 23:16, word 1 all zero, TTL 64 in word 2 bits 31:24, protocol 50 or 51 as in R3, source `sa_tun_src` in word 3, and destination `sa_tun_dst` in word 4.
- R6: Word 2 bits 15:0 hold the ones-complement of the ones-complement sum of the ten 16-bit halves of the output header, with the checksum field counted as zero.
- R7: `out_exc` is 0 when the untruncated new total length is at most `cfg_mtu`. Above the MTU it is 1 if the don't-fragment bit (input word 1 bit 14) is clear and 2 if that bit is set. Code 3 never occurs, and `out_exc` holds one value for all five words of a packet.
- R8: The first output word is valid in the cycle right after the fifth input word is accepted. Exactly five words are sent, and `out_last` is high on the fifth only.
- R9: While `out_valid` is high and `out_ready` is low, `out_data`, `out_last` and `out_exc` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mtu | input | 16 | Largest total length allowed without an exception |
| sa_is_esp | input | 1 | 1 = ESP (50), 0 = AH (51) |
| sa_tunnel | input | 1 | 1 = tunnel mode, 0 = transport mode |
| sa_tun_src | input | 32 | Tunnel source address |
| sa_tun_dst | input | 32 | Tunnel destination address |
| sa_sec_len | input | 16 | Length in bytes of the security header to be inserted |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with `in_valid` |
| in_data | input | 32 | Input header word, network byte order |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Output header word, network byte order |
| out_last | output | 1 | Marks the fifth output word |
| out_exc | output | 2 | 0 normal, 1 fragment via control processor, 2 drop |

## Verification
Only one register sits between the fifth input handshake and the output. The bench therefore drives inputs on falling edges and expects `out_valid` at the very next falling edge after the clock edge that takes the fifth word. It checks that `in_ready` has dropped at the same point. Each output word is compared at the falling edge before the clock edge that consumes it. A stalled word is compared again on every stall cycle, so holding it steady is checked cycle by cycle. The association inputs are scrambled right after the fifth word is accepted, to show that they were sampled at that handshake.

// File: rtl/secgw_pkg.sv
package secgw_pkg;

    localparam int HDR_WORDS  = 5;
    localparam int WORD_W     = 32;
    localparam int LEN_W      = 16;
    localparam int IDX_W      = $clog2(HDR_WORDS);

    localparam logic [7:0]       PROTO_AH     = 8'd51;
    localparam logic [7:0]       PROTO_ESP    = 8'd50;
    localparam logic [7:0]       TUN_TTL      = 8'd64;
    localparam logic [7:0]       VER_IHL_BASE = 8'h45;
    localparam logic [LEN_W-1:0] BASE_HDR_LEN = LEN_W'(HDR_WORDS * 4);

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_FRAG = 2'd1,
        EXC_DROP = 2'd2
    } exc_e;

    typedef struct packed {
        logic              is_esp;
        logic              tunnel;
        logic [31:0]       src;
        logic [31:0]       dst;
        logic [LEN_W-1:0]  sec_len;
    } sa_rec_t;

    typedef logic [HDR_WORDS-1:0][WORD_W-1:0] hdr_t;

    // Ones-complement checksum over all halves; caller zeroes the field.
    function automatic logic [15:0] hdr_csum(input hdr_t h);
        logic [19:0] acc;
        acc = '0;
        for (int i = 0; i < HDR_WORDS; i++) begin
            acc = acc + 20'(h[i][31:16]) + 20'(h[i][15:0]);
        end
        acc = 20'(acc[15:0]) + 20'(acc[19:16]);
        acc = 20'(acc[15:0]) + 20'(acc[19:16]);
        return ~acc[15:0];
    endfunction

endpackage

// File: rtl/secgw_collect.sv
module secgw_collect
    import secgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              done,
    output hdr_t              view
);
    logic [IDX_W-1:0] cnt;
    hdr_t             words;
    logic             accept;

    assign in_ready = !hold;
    assign accept   = in_valid && in_ready;
    assign done     = accept && (cnt == IDX_W'(HDR_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            words <= '0;
        end else if (accept) begin
            words[cnt] <= in_data;
            cnt        <= (cnt == IDX_W'(HDR_WORDS - 1)) ? '0 : cnt + 1'b1;
        end
    end

    // Present the full header, with the word in flight in its own slot.
    for (genvar g = 0; g < HDR_WORDS; g++) begin : g_view
        assign view[g] = (cnt == IDX_W'(g)) ? in_data : words[g];
    end

endmodule

// File: rtl/secgw_rewrite.sv
module secgw_rewrite
    import secgw_pkg::*;
(
    input  hdr_t             hdr_in,
    input  sa_rec_t          sa,
    input  logic [LEN_W-1:0] mtu,
    output hdr_t             hdr_out,
    output exc_e             exc
);
    logic [LEN_W+1:0] grow;
    logic [LEN_W+1:0] new_len;
    logic [7:0]       proto;
    logic             dont_frag;
    hdr_t             built;
    logic [15:0]      csum;

    always_comb begin
        proto     = sa.is_esp ? PROTO_ESP : PROTO_AH;
        dont_frag = hdr_in[1][14];
        grow      = (LEN_W+2)'(sa.sec_len) +
                    (sa.tunnel ? (LEN_W+2)'(BASE_HDR_LEN) : '0);
        new_len   = (LEN_W+2)'(hdr_in[0][15:0]) + grow;

        if (sa.tunnel) begin
            built[0] = {VER_IHL_BASE, hdr_in[0][23:16], new_len[15:0]};
            built[1] = '0;
            built[2] = {TUN_TTL, proto, 16'h0000};
            built[3] = sa.src;
            built[4] = sa.dst;
        end else begin
            built[0] = {hdr_in[0][31:16], new_len[15:0]};
            built[1] = hdr_in[1];
            built[2] = {hdr_in[2][31:24], proto, 16'h0000};
            built[3] = hdr_in[3];
            built[4] = hdr_in[4];
        end

        csum          = hdr_csum(built);
        hdr_out       = built;
        hdr_out[2]    = {built[2][31:16], csum};

        if (new_len > (LEN_W+2)'(mtu)) begin
            exc = dont_frag ? EXC_DROP : EXC_FRAG;
        end else begin
            exc = EXC_NONE;
        end
    end

endmodule

// File: rtl/secgw_emit.sv
module secgw_emit
    import secgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  hdr_t              hdr_in,
    input  exc_e              exc_in,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last,
    output exc_e              out_exc,
    output logic              busy
);
    hdr_t             held;
    logic [IDX_W-1:0] idx;
    logic             active;
    exc_e             exc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= '0;
            idx    <= '0;
            active <= 1'b0;
            exc_q  <= EXC_NONE;
        end else if (load) begin
            held   <= hdr_in;
            idx    <= '0;
            active <= 1'b1;
            exc_q  <= exc_in;
        end else if (active && out_ready) begin
            if (idx == IDX_W'(HDR_WORDS - 1)) begin
                active <= 1'b0;
                idx    <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    assign busy      = active;
    assign out_valid = active;
    assign out_data  = held[idx];
    assign out_last  = active && (idx == IDX_W'(HDR_WORDS - 1));
    assign out_exc   = exc_q;

endmodule

// File: rtl/secgw_encap.sv
module secgw_encap
    import secgw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cfg_mtu,
    input  logic        sa_is_esp,
    input  logic        sa_tunnel,
    input  logic [31:0] sa_tun_src,
    input  logic [31:0] sa_tun_dst,
    input  logic [15:0] sa_sec_len,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data,
    output logic        out_last,
    output logic [1:0]  out_exc
);
    sa_rec_t sa;
    hdr_t    view;
    hdr_t    rewritten;
    exc_e    exc_new;
    exc_e    exc_out;
    logic    done;
    logic    busy;

    assign sa = '{is_esp: sa_is_esp, tunnel: sa_tunnel, src: sa_tun_src,
                  dst: sa_tun_dst, sec_len: sa_sec_len};

    secgw_collect u_collect (
        .clk      (clk),
        .rst      (rst),
        .hold     (busy),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .done     (done),
        .view     (view)
    );

    secgw_rewrite u_rewrite (
        .hdr_in  (view),
        .sa      (sa),
        .mtu     (cfg_mtu),
        .hdr_out (rewritten),
        .exc     (exc_new)
    );

    secgw_emit u_emit (
        .clk       (clk),
        .rst       (rst),
        .load      (done),
        .hdr_in    (rewritten),
        .exc_in    (exc_new),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .out_exc   (exc_out),
        .busy      (busy)
    );

    assign out_exc = exc_out;

endmodule

// File: rtl/secgw_encap_chk.sv
module secgw_encap_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        out_last,
    input logic [1:0]  out_exc
);
    logic [2:0] beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else if (out_valid && out_ready) begin
            beat <= out_last ? 3'd0 : beat + 3'd1;
        end
    end

    p_idle_after_reset_r1: assert property (@(posedge clk)
        rst |=> !out_valid);

    p_no_input_while_sending_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    p_exc_code_legal_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_exc != 2'd3));

    p_exc_constant_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !(out_ready && out_last)) |=> $stable(out_exc));

    p_last_on_fifth_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_last == (beat == 3'd4)));

    p_hold_on_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

bind secgw_encap secgw_encap_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_exc   (out_exc)
);

// File: tb/sim_secgw_encap.sv
`timescale 1ns/1ps
module sim_secgw_encap;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_mtu = 16'd1500;
    logic        sa_is_esp = 1'b0;
    logic        sa_tunnel = 1'b0;
    logic [31:0] sa_tun_src = '0;
    logic [31:0] sa_tun_dst = '0;
    logic [15:0] sa_sec_len = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        out_last;
    logic [1:0]  out_exc;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    secgw_encap u0 (
        .clk(clk), .rst(rst), .cfg_mtu(cfg_mtu), .sa_is_esp(sa_is_esp),
        .sa_tunnel(sa_tunnel), .sa_tun_src(sa_tun_src), .sa_tun_dst(sa_tun_dst),
        .sa_sec_len(sa_sec_len), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last), .out_exc(out_exc)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [31:0] exp_w [5];
    logic [1:0]  exp_x;

    function automatic logic [15:0] ref_sum(input logic [31:0] w [5]);
        logic [31:0] s;
        s = 0;
        for (int i = 0; i < 5; i++) begin
            s = s + {16'h0, w[i][15:0]} + {16'h0, w[i][31:16]};
        end
        while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
        return ~s[15:0];
    endfunction

    task automatic model(input logic [31:0] w [5], input bit esp, input bit tun,
                         input logic [31:0] src, input logic [31:0] dst,
                         input logic [15:0] slen, input logic [15:0] mtu);
        logic [7:0]  pr;
        int unsigned tot;
        pr  = esp ? 8'd50 : 8'd51;
        tot = w[0][15:0] + slen + (tun ? 20 : 0);
        if (tun) begin
            exp_w[0] = {8'h45, w[0][23:16], tot[15:0]};
            exp_w[1] = 32'h0;
            exp_w[2] = {8'd64, pr, 16'h0};
            exp_w[3] = src;
            exp_w[4] = dst;
        end else begin
            exp_w[0] = {w[0][31:16], tot[15:0]};
            exp_w[1] = w[1];
            exp_w[2] = {w[2][31:24], pr, 16'h0};
            exp_w[3] = w[3];
            exp_w[4] = w[4];
        end
        exp_w[2][15:0] = ref_sum(exp_w);
        if (tot <= mtu) exp_x = 2'd0;
        else exp_x = w[1][14] ? 2'd2 : 2'd1;
    endtask

    function automatic string tag_of(input int i, input bit tun);
        case (i)
            0: return "R4";
            2: return "R6";
            default: return tun ? "R5" : "R3";
        endcase
    endfunction

    task automatic run_pkt(input logic [31:0] w [5], input bit esp, input bit tun,
                           input logic [31:0] src, input logic [31:0] dst,
                           input logic [15:0] slen, input logic [15:0] mtu);
        int beats;
        bit rdy;
        model(w, esp, tun, src, dst, slen, mtu);
        cfg_mtu = mtu;
        sa_is_esp = esp; sa_tunnel = tun; sa_tun_src = src;
        sa_tun_dst = dst; sa_sec_len = slen;
        for (int i = 0; i < 5; i++) begin
            if ($urandom % 4 == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = w[i];
            chk(in_ready == 1'b1, "R2", {31'b0, in_ready}, 32'd1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_data  = $urandom;
        // record changes after sampling must not matter
        sa_is_esp = ~esp; sa_tunnel = ~tun; sa_tun_src = $urandom;
        sa_tun_dst = $urandom; sa_sec_len = $urandom;
        chk(out_valid == 1'b1, "R8", {31'b0, out_valid}, 32'd1);
        chk(in_ready == 1'b0, "R2", {31'b0, in_ready}, 32'd0);
        beats = 0;
        while (beats < 5) begin
            rdy = ($urandom % 3) != 0;
            out_ready = rdy;
            chk(out_valid == 1'b1, rdy ? "R8" : "R9", {31'b0, out_valid}, 32'd1);
            chk(out_data == exp_w[beats], rdy ? tag_of(beats, tun) : "R9",
                out_data, exp_w[beats]);
            chk(out_last == (beats == 4), "R8", {31'b0, out_last},
                {31'b0, beats == 4});
            chk(out_exc == exp_x, "R7", {30'b0, out_exc}, {30'b0, exp_x});
            @(negedge clk);
            if (rdy) beats++;
        end
        out_ready = 1'b0;
        chk(out_valid == 1'b0, "R8", {31'b0, out_valid}, 32'd0);
        chk(in_ready == 1'b1, "R2", {31'b0, in_ready}, 32'd1);
    endtask

    function automatic void mk_hdr(output logic [31:0] w [5], input logic [15:0] len,
                                   input bit df);
        w[0] = {8'h45, 8'($urandom), len};
        w[1] = {16'($urandom), 1'b0, df, 14'($urandom)};
        w[2] = {8'($urandom), 8'd6, 16'($urandom)};
        w[3] = $urandom;
        w[4] = $urandom;
    endfunction

    initial begin
        logic [31:0] w [5];
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", {31'b0, out_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", {31'b0, out_valid}, 32'd0);
        chk(in_ready == 1'b1, "R1", {31'b0, in_ready}, 32'd1);

        // R3 transport ESP, length lands exactly on the MTU
        mk_hdr(w, 16'd1476, 1'b0);
        run_pkt(w, 1'b1, 1'b0, 32'h0A000001, 32'h0A000002, 16'd24, 16'd1500);
        // R7 one over the MTU with DF clear -> fragment code
        mk_hdr(w, 16'd1477, 1'b0);
        run_pkt(w, 1'b1, 1'b0, 32'h0, 32'h0, 16'd24, 16'd1500);
        // R7 over the MTU with DF set -> drop code
        mk_hdr(w, 16'd1477, 1'b1);
        run_pkt(w, 1'b0, 1'b0, 32'h0, 32'h0, 16'd24, 16'd1500);
        // R5 tunnel AH, exactly at the MTU including the 20 extra bytes
        mk_hdr(w, 16'd1456, 1'b1);
        run_pkt(w, 1'b0, 1'b1, 32'hC0A80001, 32'hC0A80102, 16'd24, 16'd1500);
        // R4 tunnel where the sum passes 65535
        mk_hdr(w, 16'd65530, 1'b0);
        run_pkt(w, 1'b1, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'd16, 16'hFFFF);

        for (int n = 0; n < 60; n++) begin
            mk_hdr(w, 16'(20 + $urandom % 1700), 1'($urandom));
            run_pkt(w, 1'($urandom), 1'($urandom), $urandom, $urandom,
                    16'(8 + $urandom % 64), 16'(1280 + $urandom % 400));
        end

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule